// File: doc/BRIEF.md
# Two-Phase Serial Frame Transmitter

This block turns a stream of parallel words into serial frames. A frame contains one phase or two phases. Each phase has its own word count and its own word length. The frame timing is taken from the configuration that is present when a start request is accepted, so the configuration inputs only need to be stable on that edge.

On an accepted start, the block drives a frame sync pulse one clock wide. It then shifts the words out on a single data line, beginning one clock after that pulse. A word is requested from the upstream source at the start of each word slot. If the source cannot supply a word there, the slot is sent as zeros and the frame keeps its length.

Before a frame starts, its configuration is checked. An unknown word-length code, or a frame longer than the serial-clock budget, is refused with a one-cycle error pulse, and no frame is started.

Top module: `frame_tx`

## Requirements
- R1: `dual` = 0 gives frames of phase A only. `dual` = 1 gives phase A followed by phase B in the same frame, each phase using its own count and its own length. `busy` is high from the sync cycle through the last data bit, and drops on the next cycle.
- R2: A count field holds the number of words in its phase minus one. A field value of 0 sends exactly one word.
- R3: Length codes map as 0→8, 1→12, 2→16, 3→20, 4→24 and 5→32 bits per word.
- R4: Codes 6 and 7 are reserved. A reserved code in phase A, or in phase B while `dual` = 1, gives a one-cycle `cfg_err` pulse on the cycle after `start`, with no `fs` pulse and `busy` staying low. A reserved phase B code is ignored when `dual` = 0.
- R5: A frame whose total bit count is above 4096 is refused in the same way as in R4. A frame of exactly 4096 bits is sent.
- R6: When `start` is sampled while the block is idle, `fs` is high for exactly the following cycle. A `start` while `busy` is high is ignored.
- R7: `sd` is low during the `fs` cycle. The first data bit appears on the cycle right after it, and bits follow back to back with no gaps between words or phases.
- R8: Each word is sent MSB first, using only the low N bits of `in_data`, where N is the length of the phase in progress.
- R9: `in_ready` is high for one cycle before each word slot, and a word transfers when `in_valid` is also high. If no word transfers, that slot is sent as N zeros and `underrun` pulses during the slot's first bit.
- R10: Out of reset, and whenever the block is idle, `fs`, `sd`, `busy`, `in_ready`, `cfg_err` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame request, sampled while idle |
| dual | input | 1 | 0 = one phase per frame, 1 = two phases |
| cnt_a | input | 7 | Phase A word count minus one |
| cnt_b | input | 7 | Phase B word count minus one |
| len_a | input | 3 | Phase A word length code |
| len_b | input | 3 | Phase B word length code |
| in_valid | input | 1 | Upstream word available |
| in_data | input | 32 | Upstream word; low N bits are sent |
| in_ready | output | 1 | Word requested for the next slot |
| fs | output | 1 | One-cycle frame sync |
| sd | output | 1 | Serial data |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Start refused because of a bad configuration |
| underrun | output | 1 | Current slot had no word |

## Verification
Two events can land on the same clock edge. One is the crossing from phase A into phase B. The other is the word request for the first phase B slot, and that request must already use the phase B length. Dual-phase frames with different lengths per phase are run against a scoreboard that checks every serial bit. Any misaligned or truncated first word in phase B then shows up as a bit mismatch. A second case is a slot boundary where the source has nothing ready. The bench withholds words partway through a frame, then checks the zero slots, the underrun pulse count and the total frame length.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

   localparam int LEN_W = 6;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SYNC,
      ST_DATA
   } ftx_state_e;

   // bits per word for a length code; 0 for reserved codes
   function automatic logic [LEN_W-1:0] code_bits(input logic [2:0] code);
      case (code)
         3'd0:    return 6'd8;
         3'd1:    return 6'd12;
         3'd2:    return 6'd16;
         3'd3:    return 6'd20;
         3'd4:    return 6'd24;
         3'd5:    return 6'd32;
         default: return 6'd0;
      endcase
   endfunction

   function automatic logic code_legal(input logic [2:0] code);
      return code <= 3'd5;
   endfunction

endpackage

// File: rtl/ftx_cfg_check.sv
module ftx_cfg_check
   import ftx_pkg::*;
#(
   parameter int CNT_W    = 7,
   parameter int MAX_BITS = 4096
) (
   input  logic             dual,
   input  logic [CNT_W-1:0] cnt_a,
   input  logic [CNT_W-1:0] cnt_b,
   input  logic [2:0]       len_a,
   input  logic [2:0]       len_b,
   output logic             bad
);
   localparam int WC_W   = CNT_W + 1;
   localparam int PROD_W = WC_W + LEN_W;
   localparam int SUM_W  = PROD_W + 1;

   logic [WC_W-1:0]   words_a, words_b;
   logic [PROD_W-1:0] bits_a, bits_b;
   logic [SUM_W-1:0]  total;
   logic              code_bad;

   always_comb begin
      words_a  = {1'b0, cnt_a} + WC_W'(1);
      words_b  = {1'b0, cnt_b} + WC_W'(1);
      bits_a   = PROD_W'(words_a) * PROD_W'(code_bits(len_a));
      bits_b   = dual ? PROD_W'(words_b) * PROD_W'(code_bits(len_b)) : '0;
      total    = SUM_W'(bits_a) + SUM_W'(bits_b);
      code_bad = !code_legal(len_a) || (dual && !code_legal(len_b));
      bad      = code_bad || (total > SUM_W'(MAX_BITS));
   end

endmodule

// File: rtl/ftx_phase_seq.sv
module ftx_phase_seq
   import ftx_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cfg_bad,
   input  logic             dual,
   input  logic [CNT_W-1:0] cnt_a,
   input  logic [CNT_W-1:0] cnt_b,
   input  logic [2:0]       len_a,
   input  logic [2:0]       len_b,
   output logic             fs,
   output logic             active,
   output logic             busy,
   output logic             load,
   output logic [LEN_W-1:0] load_len,
   output logic             cfg_err
);
   ftx_state_e       state;
   logic             dual_q, phase_q;
   logic [CNT_W-1:0] cnt_a_q, cnt_b_q, word_q;
   logic [LEN_W-1:0] bits_a_q, bits_b_q, bit_q;

   logic [LEN_W-1:0] cur_len;
   logic [CNT_W-1:0] cur_cnt;
   logic             word_end, last_word, final_slot, to_phase_b;

   always_comb begin
      cur_len    = phase_q ? bits_b_q : bits_a_q;
      cur_cnt    = phase_q ? cnt_b_q : cnt_a_q;
      word_end   = (state == ST_DATA) && (bit_q == cur_len - LEN_W'(1));
      last_word  = (word_q == cur_cnt);
      final_slot = last_word && (phase_q || !dual_q);
      to_phase_b = word_end && last_word && !phase_q && dual_q;
      load       = (state == ST_SYNC) || (word_end && !final_slot);
      load_len   = to_phase_b ? bits_b_q : cur_len;
      active     = (state == ST_DATA);
      busy       = (state != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         fs       <= 1'b0;
         cfg_err  <= 1'b0;
         dual_q   <= 1'b0;
         phase_q  <= 1'b0;
         cnt_a_q  <= '0;
         cnt_b_q  <= '0;
         bits_a_q <= '0;
         bits_b_q <= '0;
         word_q   <= '0;
         bit_q    <= '0;
      end else begin
         fs      <= 1'b0;
         cfg_err <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (cfg_bad) begin
                     cfg_err <= 1'b1;
                  end else begin
                     state    <= ST_SYNC;
                     fs       <= 1'b1;
                     dual_q   <= dual;
                     cnt_a_q  <= cnt_a;
                     cnt_b_q  <= cnt_b;
                     bits_a_q <= code_bits(len_a);
                     bits_b_q <= code_bits(len_b);
                     phase_q  <= 1'b0;
                  end
               end
            end
            ST_SYNC: begin
               state  <= ST_DATA;
               word_q <= '0;
               bit_q  <= '0;
            end
            ST_DATA: begin
               if (word_end) begin
                  bit_q <= '0;
                  if (final_slot) begin
                     state <= ST_IDLE;
                  end else if (to_phase_b) begin
                     phase_q <= 1'b1;
                     word_q  <= '0;
                  end else begin
                     word_q <= word_q + CNT_W'(1);
                  end
               end else begin
                  bit_q <= bit_q + LEN_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter
   import ftx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              active,
   input  logic              valid,
   input  logic [DATA_W-1:0] din,
   input  logic [LEN_W-1:0]  len,
   output logic              sd,
   output logic              underrun
);
   logic [DATA_W-1:0] sh;
   logic [LEN_W-1:0]  align;

   always_comb begin
      align = LEN_W'(DATA_W) - len;
      sd    = active && sh[DATA_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         underrun <= 1'b0;
      end else begin
         underrun <= 1'b0;
         if (load) begin
            sh       <= valid ? (din << align) : '0;
            underrun <= !valid;
         end else if (active) begin
            sh <= sh << 1;
         end
      end
   end

endmodule

// File: rtl/frame_tx.sv
module frame_tx
   import ftx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 7,
   parameter int MAX_BITS = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dual,
   input  logic [CNT_W-1:0]  cnt_a,
   input  logic [CNT_W-1:0]  cnt_b,
   input  logic [2:0]        len_a,
   input  logic [2:0]        len_b,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              fs,
   output logic              sd,
   output logic              busy,
   output logic              cfg_err,
   output logic              underrun
);
   localparam int SUM_LIMIT = 1 << (CNT_W + 2 + LEN_W);

   generate
      if (DATA_W < 32 || DATA_W >= 64) begin : g_bad_width
         $error("frame_tx: DATA_W must lie in 32..63");
      end
      if (CNT_W < 1 || CNT_W > 12) begin : g_bad_cnt
         $error("frame_tx: CNT_W out of range");
      end
      if (MAX_BITS < 8 || MAX_BITS >= SUM_LIMIT) begin : g_bad_max
         $error("frame_tx: MAX_BITS not representable");
      end
   endgenerate

   logic             cfg_bad;
   logic             active, load;
   logic [LEN_W-1:0] load_len;

   ftx_cfg_check #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS)) u_check (
      .dual  (dual),
      .cnt_a (cnt_a),
      .cnt_b (cnt_b),
      .len_a (len_a),
      .len_b (len_b),
      .bad   (cfg_bad)
   );

   ftx_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cfg_bad  (cfg_bad),
      .dual     (dual),
      .cnt_a    (cnt_a),
      .cnt_b    (cnt_b),
      .len_a    (len_a),
      .len_b    (len_b),
      .fs       (fs),
      .active   (active),
      .busy     (busy),
      .load     (load),
      .load_len (load_len),
      .cfg_err  (cfg_err)
   );

   ftx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .active   (active),
      .valid    (in_valid),
      .din      (in_data),
      .len      (load_len),
      .sd       (sd),
      .underrun (underrun)
   );

   assign in_ready = load;

endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic in_valid,
   input logic in_ready,
   input logic fs,
   input logic sd,
   input logic busy,
   input logic cfg_err,
   input logic underrun
);
   // R6
   fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs |=> !fs);

   // R6
   fs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs |-> ($past(start) && !$past(busy)));

   // R7
   fs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs |-> !sd);

   // R1
   fs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs |=> busy);

   // R9
   underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> $past(in_ready && !in_valid));

   // R4
   cfg_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!busy && !fs));

   // R10
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sd && !in_ready && !underrun));

endmodule

bind frame_tx frame_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .fs       (fs),
   .sd       (sd),
   .busy     (busy),
   .cfg_err  (cfg_err),
   .underrun (underrun)
);

// File: tb/frame_tx_tb.sv
module frame_tx_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dual = 1'b0;
   logic [6:0]  cnt_a = '0, cnt_b = '0;
   logic [2:0]  len_a = '0, len_b = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready, fs, sd, busy, cfg_err, underrun;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] word_q[$];
   bit          exp_q[$];
   int          exp_und = 0;
   bit          exp_frame = 0;
   bit          frame_done = 0;
   bit          pend = 0;

   bit in_frame = 0;
   int rem = 0;
   int und_seen = 0;

   always #10 clk = ~clk;

   frame_tx u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dual(dual),
      .cnt_a(cnt_a), .cnt_b(cnt_b), .len_a(len_a), .len_b(len_b),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .fs(fs), .sd(sd), .busy(busy), .cfg_err(cfg_err), .underrun(underrun)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int bits_for(input logic [2:0] c);
      case (c)
         3'd0: return 8;
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 20;
         3'd4: return 24;
         default: return 32;
      endcase
   endfunction

   // source: transfer happens at posedge, so pop on the following negedge
   always @(negedge clk) begin
      if (pend) void'(word_q.pop_front());
      in_valid = (word_q.size() > 0);
      in_data  = (word_q.size() > 0) ? word_q[0] : 32'h0;
      pend     = in_ready && in_valid;
   end

   // monitor: scoreboard of serial bits
   always @(negedge clk) begin
      if (rst_n) begin
         if (fs) begin
            check(!in_frame && exp_frame, "R6 unexpected fs", 1, 0);
            check(sd == 1'b0, "R7 sd during fs", sd, 0);
            in_frame = 1;
            rem = exp_q.size();
            und_seen = 0;
         end else if (in_frame) begin
            if (rem > 0) begin
               bit e;
               e = exp_q.pop_front();
               check(sd == e, "R8 serial bit", sd, e);
               check(busy == 1'b1, "R1 busy in frame", busy, 1);
               if (underrun) und_seen++;
               rem--;
            end else begin
               check(busy == 1'b0, "R1 frame length", busy, 0);
               check(und_seen == exp_und, "R9 underrun count", und_seen, exp_und);
               in_frame = 0;
               exp_frame = 0;
               frame_done = 1;
            end
         end else begin
            check(sd == 1'b0 && in_ready == 1'b0, "R10 idle outputs", sd, 0);
         end
      end
   end

   task automatic run_frame(input bit d, input logic [6:0] ca, input logic [6:0] cb,
                            input logic [2:0] la, input logic [2:0] lb,
                            input int avail, input logic [31:0] seed, input bit spam);
      int slot = 0;
      exp_und = 0;
      for (int p = 0; p < (d ? 2 : 1); p++) begin
         int n = bits_for(p == 0 ? la : lb);
         int cnt = (p == 0 ? int'(ca) : int'(cb)) + 1;
         for (int i = 0; i < cnt; i++) begin
            logic [31:0] w;
            w = seed ^ (32'(slot) * 32'h9E37_79B1);
            w = {w[12:0], w[31:13]} ^ 32'h5A5A_C3C3;
            if (slot < avail) word_q.push_back(w);
            else begin
               w = '0;
               exp_und++;
            end
            for (int b = n - 1; b >= 0; b--) exp_q.push_back(w[b]);
            slot++;
         end
      end
      exp_frame = 1;
      frame_done = 0;
      @(negedge clk);
      dual = d; cnt_a = ca; cnt_b = cb; len_a = la; len_b = lb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (spam) begin
         repeat (6) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (frame_done);
      repeat (3) @(negedge clk);
      check(word_q.size() == 0, "R2 words consumed", word_q.size(), 0);
   endtask

   task automatic reject(input bit d, input logic [6:0] ca, input logic [6:0] cb,
                         input logic [2:0] la, input logic [2:0] lb, input string req);
      @(negedge clk);
      dual = d; cnt_a = ca; cnt_b = cb; len_a = la; len_b = lb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(cfg_err == 1'b1, req, cfg_err, 1);
      check(fs == 1'b0, req, fs, 0);
      @(negedge clk);
      check(cfg_err == 1'b0, req, cfg_err, 0);
      check(busy == 1'b0, req, busy, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check({fs, sd, busy, in_ready, cfg_err, underrun} == 6'b0, "R10 reset outputs",
            {fs, sd, busy, in_ready, cfg_err, underrun}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 one-word single frame, 8 bits (R3 code 0)
      run_frame(1'b0, 7'd0, 7'd0, 3'd0, 3'd0, 1, 32'h1234_5678, 1'b0);
      // R1 dual: 2x16 then 10x8, with a start while busy (R6)
      run_frame(1'b1, 7'd1, 7'd9, 3'd2, 3'd0, 12, 32'hCAFE_0001, 1'b1);
      // R3 codes 1 and 3 in two phases
      run_frame(1'b1, 7'd2, 7'd1, 3'd1, 3'd3, 5, 32'h0BAD_F00D, 1'b0);
      // R3 code 4, then code 5
      run_frame(1'b0, 7'd3, 7'd0, 3'd4, 3'd0, 4, 32'h7777_AAAA, 1'b0);
      run_frame(1'b0, 7'd1, 7'd0, 3'd5, 3'd0, 2, 32'hDEAD_BEEF, 1'b0);
      // R9 underrun: 3 slots, 1 word
      run_frame(1'b0, 7'd2, 7'd0, 3'd2, 3'd0, 1, 32'h0F0F_1234, 1'b0);
      // R9 underrun crossing into phase B
      run_frame(1'b1, 7'd0, 7'd1, 3'd0, 3'd1, 2, 32'h3141_5926, 1'b0);
      // R4 reserved phase B code ignored in single mode
      run_frame(1'b0, 7'd0, 7'd0, 3'd1, 3'd7, 1, 32'h2718_2818, 1'b0);
      // R5 exactly 4096 bits
      run_frame(1'b0, 7'd127, 7'd0, 3'd5, 3'd0, 128, 32'hA5A5_0F0F, 1'b0);

      // R4 reserved codes
      reject(1'b0, 7'd0, 7'd0, 3'd6, 3'd0, "R4 reserved phase A");
      reject(1'b1, 7'd0, 7'd0, 3'd0, 3'd7, "R4 reserved phase B");
      // R5 over budget: 4096 + 8
      reject(1'b1, 7'd127, 7'd0, 3'd5, 3'd0, "R5 too many bits");

      // after refusals the block still runs
      run_frame(1'b1, 7'd0, 7'd0, 3'd5, 3'd2, 2, 32'h0000_FFFF, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule